// File: doc/BRIEF.md
# DRAM Strobe-Sequence Decoder

This block sits on the device side of an asynchronous DRAM strobe bus and watches the row strobe, column strobe, write enable and output enable as a clocked, oversampled model. The system clock must be fast enough that every strobe level lasts at least one clock. The block works out what kind of memory cycle the controller issued purely from the order in which the strobe edges arrive. It captures the row and column addresses at the edges that define them. It also captures write data at the edge that commits a write, and computes when a real part would drive its data pins.

For refresh cycles that take their row from inside the device, the block keeps its own refresh row counter. It reports that row as the row of the cycle. Each completed cycle produces a one-clock report carrying a 3-bit cycle kind. A controller testbench can use the reports, the latched addresses, the write strobe and the drive flag as the front end of a scoreboard against a small behavioural memory.

All outputs are registered. A pin change sampled at one rising clock edge shows on the outputs right after that same edge.

Top module: `dram_strobe_decoder`

## Requirements
- R1: After reset, rpt_valid, wr_stb and dq_oe are 0, row_addr and col_addr are 0, and the refresh counter is 0.
- R2: In a normal cycle, row_addr takes addr at the sample where ras_n falls while cas_n is high. col_addr takes addr[COL_W-1:0] at every cas_n fall while ras_n is low; in page mode each new column strobe replaces it.
- R3: At the sample where ras_n rises after an active cycle, rpt_valid pulses for exactly one clock with rpt_kind set. The codes are 1 read, 2 early write, 3 delayed write, 4 RAS-only refresh, 5 CAS-before-RAS refresh, 6 hidden refresh and 7 illegal ordering. In page mode the kind is that of the last column access.
- R4: If we_n is low when cas_n falls with ras_n low, the cycle is an early write. wr_stb pulses for one clock, wr_data takes din at that sample, and dq_oe stays 0.
- R5: If we_n falls while cas_n is low after a read column strobe, the cycle is a delayed write. wr_stb pulses with wr_data taken from din at the we_n fall, and dq_oe keeps its read state.
- R6: dq_oe is 1 only after a read column strobe issued with ras_n low, and only while cas_n and oe_n are both low. It returns to 0 in the clock after oe_n or cas_n rises.
- R7: A cycle in which cas_n stays high while ras_n is low reports kind 4. The row comes from addr, and dq_oe stays 0.
- R8: When cas_n is already low at the ras_n fall and no read data is being held, the cycle reports kind 5. row_addr shows the refresh counter value, and addr is ignored.
- R9: Back-to-back CAS-before-RAS refreshes are issued by holding cas_n low and toggling only ras_n; each one reports kind 5 with the next counter row.
- R10: When cas_n stays low from a read and ras_n rises and falls again, the new cycle is a hidden refresh. It reports kind 6, uses the counter row, and dq_oe stays 1 throughout.
- R11: The refresh counter advances by one at the end of each kind 5 or kind 6 cycle and wraps from 2^ROW_W-1 to 0.
- R12: If cas_n falls and then rises while ras_n stays high with no ras_n fall in between, a kind 7 report pulses at the cas_n rise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | ROW_W | Multiplexed address lines |
| din | input | DQ_W | Data presented by the controller on writes |
| rpt_valid | output | 1 | One-clock pulse when a cycle report is ready |
| rpt_kind | output | 3 | Cycle kind code (see R3) |
| row_addr | output | ROW_W | Row of the current or last cycle |
| col_addr | output | COL_W | Last latched column |
| wr_stb | output | 1 | One-clock pulse when a write commits |
| wr_data | output | DQ_W | Data captured with the last write |
| dq_oe | output | 1 | A real device would drive its data pins |

## Verification
The hardest state to reach is a hidden refresh. Data from a read has to stay in force while the row strobe finishes one cycle and opens another with the column strobe never released, and the counter row must then replace the external row. The stimulus issues a read with output enable low and keeps cas_n low while ras_n is toggled. Drive is sampled between the two row cycles and during the refresh. Counter wrap is reached by a long train of column-held refreshes whose row the bench tracks on its own.

// File: rtl/dsd_pkg.sv
package dsd_pkg;

    typedef enum logic [2:0] {
        CK_NONE   = 3'd0,
        CK_READ   = 3'd1,
        CK_EWR    = 3'd2,
        CK_LWR    = 3'd3,
        CK_RONLY  = 3'd4,
        CK_CBR    = 3'd5,
        CK_HIDDEN = 3'd6,
        CK_ERR    = 3'd7
    } cyc_kind_e;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_ACT  = 2'd1,
        PH_IREF = 2'd2
    } phase_e;

endpackage

// File: rtl/dsd_strobe_edge.sv
module dsd_strobe_edge #(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pin_n,
    output logic [W-1:0] fall,
    output logic [W-1:0] rise
);
    logic [W-1:0] prev_d, prev_q;

    always_comb begin
        prev_d = pin_n;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '1;
        else        prev_q <= prev_d;
    end

    for (genvar i = 0; i < W; i++) begin : g_bit
        assign fall[i] =  prev_q[i] & ~pin_n[i];
        assign rise[i] = ~prev_q[i] &  pin_n[i];
    end

endmodule

// File: rtl/dsd_rfsh_ctr.sv
module dsd_rfsh_ctr #(
    parameter int ROW_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    output logic [ROW_W-1:0] cnt
);
    logic [ROW_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (inc) cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign cnt = cnt_q;

    a_r11_step: assert property (@(posedge clk) disable iff (!rst_n)
        inc |=> cnt == ROW_W'($past(cnt) + 1'b1));

    a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !inc |=> $stable(cnt));

endmodule

// File: rtl/dram_strobe_decoder.sv
module dram_strobe_decoder
    import dsd_pkg::*;
#(
    parameter int ROW_W = 12,
    parameter int COL_W = 10,
    parameter int DQ_W  = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ras_n,
    input  logic             cas_n,
    input  logic             we_n,
    input  logic             oe_n,
    input  logic [ROW_W-1:0] addr,
    input  logic [DQ_W-1:0]  din,
    output logic             rpt_valid,
    output logic [2:0]       rpt_kind,
    output logic [ROW_W-1:0] row_addr,
    output logic [COL_W-1:0] col_addr,
    output logic             wr_stb,
    output logic [DQ_W-1:0]  wr_data,
    output logic             dq_oe
);
    localparam int NPIN  = 3;
    localparam int P_RAS = 0;
    localparam int P_CAS = 1;
    localparam int P_WE  = 2;

    typedef struct packed {
        phase_e           ph;
        cyc_kind_e        kind;
        logic             accessed;
        logic             hid;
        logic             rd_hold;
        logic             cas_early;
        logic             rpt_valid;
        cyc_kind_e        rpt_kind;
        logic [ROW_W-1:0] row;
        logic [COL_W-1:0] col;
        logic             wr_stb;
        logic [DQ_W-1:0]  wdata;
        logic             dq_oe;
    } st_t;

    st_t d, q;

    logic [NPIN-1:0]  fall, rise;
    logic             ras_fall, ras_rise, cas_fall, cas_rise, we_fall;
    logic             bump;
    logic [ROW_W-1:0] ref_row;

    dsd_strobe_edge #(.W(NPIN)) u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .pin_n ({we_n, cas_n, ras_n}),
        .fall  (fall),
        .rise  (rise)
    );

    dsd_rfsh_ctr #(.ROW_W(ROW_W)) u_ctr (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (bump),
        .cnt   (ref_row)
    );

    assign ras_fall = fall[P_RAS];
    assign ras_rise = rise[P_RAS];
    assign cas_fall = fall[P_CAS];
    assign cas_rise = rise[P_CAS];
    assign we_fall  = fall[P_WE];

    always_comb begin
        d           = q;
        d.rpt_valid = 1'b0;
        d.wr_stb    = 1'b0;
        bump        = 1'b0;

        // opening a row cycle: column strobe already low selects internal row
        if (ras_fall) begin
            d.cas_early = 1'b0;
            if (!cas_n && !cas_fall) begin
                d.ph  = PH_IREF;
                d.hid = q.rd_hold;
                d.row = ref_row;
            end else begin
                d.ph       = PH_ACT;
                d.row      = addr;
                d.accessed = 1'b0;
                d.kind     = CK_READ;
                d.hid      = 1'b0;
            end
        end else if (q.ph == PH_ACT) begin
            if (cas_fall) begin
                d.col      = addr[COL_W-1:0];
                d.accessed = 1'b1;
                if (!we_n) begin
                    d.kind    = CK_EWR;
                    d.wr_stb  = 1'b1;
                    d.wdata   = din;
                    d.rd_hold = 1'b0;
                end else begin
                    d.kind    = CK_READ;
                    d.rd_hold = 1'b1;
                end
            end else if (we_fall && !cas_n && q.accessed && q.kind == CK_READ) begin
                d.kind   = CK_LWR;
                d.wr_stb = 1'b1;
                d.wdata  = din;
            end
        end

        if (cas_rise) d.rd_hold = 1'b0;

        // column strobe dropped with no row cycle open
        if (cas_fall && ras_n && !ras_rise) d.cas_early = 1'b1;

        if (cas_rise && ras_n && q.cas_early) begin
            d.rpt_valid = 1'b1;
            d.rpt_kind  = CK_ERR;
            d.cas_early = 1'b0;
        end

        if (ras_rise && q.ph != PH_IDLE) begin
            d.rpt_valid = 1'b1;
            if (q.ph == PH_IREF) begin
                d.rpt_kind = q.hid ? CK_HIDDEN : CK_CBR;
                bump       = 1'b1;
            end else begin
                d.rpt_kind = q.accessed ? q.kind : CK_RONLY;
            end
            d.ph = PH_IDLE;
        end

        d.dq_oe = d.rd_hold && !cas_n && !oe_n;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.ph        <= PH_IDLE;
            q.kind      <= CK_NONE;
            q.accessed  <= 1'b0;
            q.hid       <= 1'b0;
            q.rd_hold   <= 1'b0;
            q.cas_early <= 1'b0;
            q.rpt_valid <= 1'b0;
            q.rpt_kind  <= CK_NONE;
            q.row       <= '0;
            q.col       <= '0;
            q.wr_stb    <= 1'b0;
            q.wdata     <= '0;
            q.dq_oe     <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign rpt_valid = q.rpt_valid;
    assign rpt_kind  = q.rpt_kind;
    assign row_addr  = q.row;
    assign col_addr  = q.col;
    assign wr_stb    = q.wr_stb;
    assign wr_data   = q.wdata;
    assign dq_oe     = q.dq_oe;

    a_r6_drive_needs_pins: assert property (@(posedge clk) disable iff (!rst_n)
        dq_oe |-> $past(!cas_n && !oe_n));

    a_r4_write_in_row: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |-> $past(!ras_n));

    a_r3_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rpt_valid |=> !rpt_valid);

    a_r12_err_ras_high: assert property (@(posedge clk) disable iff (!rst_n)
        (rpt_valid && rpt_kind == CK_ERR) |-> $past(ras_n));

    a_r7_ronly_no_drive: assert property (@(posedge clk) disable iff (!rst_n)
        (rpt_valid && rpt_kind == CK_RONLY) |-> !dq_oe);

endmodule

// File: tb/sim_dram_strobe_decoder.sv
module sim_dram_strobe_decoder;

    localparam int ROW_W = 12;
    localparam int COL_W = 10;
    localparam int DQ_W  = 4;
    localparam int NROWS = 1 << ROW_W;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
    logic [ROW_W-1:0] addr = '0;
    logic [DQ_W-1:0]  din = '0;
    logic             rpt_valid, wr_stb, dq_oe;
    logic [2:0]       rpt_kind;
    logic [ROW_W-1:0] row_addr;
    logic [COL_W-1:0] col_addr;
    logic [DQ_W-1:0]  wr_data;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    dram_strobe_decoder #(.ROW_W(ROW_W), .COL_W(COL_W), .DQ_W(DQ_W)) u0 (
        .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
        .oe_n(oe_n), .addr(addr), .din(din), .rpt_valid(rpt_valid),
        .rpt_kind(rpt_kind), .row_addr(row_addr), .col_addr(col_addr),
        .wr_stb(wr_stb), .wr_data(wr_data), .dq_oe(dq_oe)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s act=%0h exp=%0h t=%0t", tag, act, exp, $time);
        end
    endtask

    task automatic tk(input int n);
        repeat (n) @(negedge clk);
    endtask

    // ---------------- behavioural reference model ----------------
    // mode: 0 no row open, 1 external row open, 2 internal-row refresh open
    int m_mode = 0, m_last = 0, m_ctr = 0;
    int m_row = 0, m_col = 0, m_wd = 0, m_kind = 0;
    bit m_used = 0, m_hid = 0, m_hold = 0, m_stray = 0;
    bit m_rv = 0, m_ws = 0, m_oe = 0;
    bit pr = 1, pc = 1, pw = 1;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_mode = 0; m_last = 0; m_ctr = 0; m_row = 0; m_col = 0; m_wd = 0;
            m_kind = 0; m_used = 0; m_hid = 0; m_hold = 0; m_stray = 0;
            m_rv = 0; m_ws = 0; m_oe = 0; pr = 1; pc = 1; pw = 1;
        end else begin
            m_rv = 0;
            m_ws = 0;
            if (pr && !ras_n) begin
                m_stray = 0;
                if (!pc && !cas_n) begin
                    m_mode = 2; m_hid = m_hold; m_row = m_ctr;
                end else begin
                    m_mode = 1; m_row = addr; m_used = 0; m_last = 1;
                end
            end else if (m_mode == 1) begin
                if (pc && !cas_n) begin
                    m_col = addr % (1 << COL_W);
                    m_used = 1;
                    if (!we_n) begin m_last = 2; m_ws = 1; m_wd = din; m_hold = 0; end
                    else       begin m_last = 1; m_hold = 1; end
                end else if (pw && !we_n && !cas_n && m_used && m_last == 1) begin
                    m_last = 3; m_ws = 1; m_wd = din;
                end
            end
            if (!pc && cas_n) m_hold = 0;
            if (pc && !cas_n && ras_n && pr) m_stray = 1;
            if (!pc && cas_n && ras_n && m_stray) begin
                m_rv = 1; m_kind = 7; m_stray = 0;
            end
            if (!pr && ras_n && m_mode != 0) begin
                m_rv = 1;
                if (m_mode == 2) begin
                    m_kind = m_hid ? 6 : 5;
                    m_ctr = (m_ctr + 1) % NROWS;
                end else begin
                    m_kind = m_used ? m_last : 4;
                end
                m_mode = 0;
            end
            m_oe = m_hold && !cas_n && !oe_n;
            pr = ras_n; pc = cas_n; pw = we_n;
        end
    end

    // every-clock comparison against the model
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            chk(rpt_valid == m_rv, "R3 rpt_valid", rpt_valid, m_rv);
            if (m_rv) chk(rpt_kind == m_kind, "R3 rpt_kind", rpt_kind, m_kind);
            chk(row_addr == m_row, "R2 row_addr", row_addr, m_row);
            chk(col_addr == m_col, "R2 col_addr", col_addr, m_col);
            chk(wr_stb == m_ws, "R4 wr_stb", wr_stb, m_ws);
            if (m_ws) chk(wr_data == m_wd, "R5 wr_data", wr_data, m_wd);
            chk(dq_oe == m_oe, "R6 dq_oe", dq_oe, m_oe);
        end
    end

    // report and write monitor
    int last_kind = 0, nrep = 0, nwr = 0, last_wd = 0;
    always @(negedge clk) begin
        if (rpt_valid) begin last_kind = rpt_kind; nrep++; end
        if (wr_stb) begin nwr++; last_wd = wr_data; end
    end

    // ---------------- directed stimulus ----------------
    int exp_ref = 0;

    task automatic open_read(input int r, input int c);
        addr = ROW_W'(r); ras_n = 1'b0; tk(1);
        addr = ROW_W'(c); tk(1);
        cas_n = 1'b0; tk(1);
    endtask

    task automatic close_cycle();
        ras_n = 1'b1; tk(1);
        cas_n = 1'b1; we_n = 1'b1; tk(2);
    endtask

    task automatic cbr_pulse();
        ras_n = 1'b0; tk(1);
        ras_n = 1'b1; tk(1);
        exp_ref = (exp_ref + 1) % NROWS;
    endtask

    initial begin
        int w0, r0;
        tk(3);
        rst_n = 1'b1;
        tk(1);
        // R1 reset state
        chk(rpt_valid == 0, "R1 rpt_valid", rpt_valid, 0);
        chk(dq_oe == 0 && wr_stb == 0, "R1 strobes", {dq_oe, wr_stb}, 0);
        chk(row_addr == 0 && col_addr == 0, "R1 addr", row_addr, 0);
        tk(2);

        // R2 / R6 read with output enable toggling
        oe_n = 1'b0;
        open_read('h5A3, 'h1C7);
        tk(1);
        chk(dq_oe == 1, "R6 read drive", dq_oe, 1);
        chk(row_addr == 'h5A3, "R2 row", row_addr, 'h5A3);
        chk(col_addr == 'h1C7, "R2 col", col_addr, 'h1C7);
        oe_n = 1'b1; tk(1);
        chk(dq_oe == 0, "R6 oe high", dq_oe, 0);
        oe_n = 1'b0; tk(1);
        chk(dq_oe == 1, "R6 oe low again", dq_oe, 1);
        close_cycle();
        chk(last_kind == 1, "R3 read kind", last_kind, 1);
        chk(dq_oe == 0, "R6 cas high", dq_oe, 0);

        // R4 early write
        w0 = nwr;
        addr = 'h0F0; ras_n = 1'b0; tk(1);
        addr = 'h2AA; we_n = 1'b0; din = 4'hA; tk(1);
        cas_n = 1'b0; tk(1);
        din = 4'h3; tk(1);
        chk(nwr == w0 + 1, "R4 one strobe", nwr, w0 + 1);
        chk(last_wd == 'hA, "R4 data at cas", last_wd, 'hA);
        chk(dq_oe == 0, "R4 no drive", dq_oe, 0);
        close_cycle();
        chk(last_kind == 2, "R4 kind", last_kind, 2);

        // R5 delayed write after a read strobe
        w0 = nwr;
        open_read('h123, 'h045);
        tk(1);
        chk(dq_oe == 1, "R5 read part", dq_oe, 1);
        din = 4'h5; we_n = 1'b0; tk(2);
        chk(nwr == w0 + 1, "R5 one strobe", nwr, w0 + 1);
        chk(last_wd == 5, "R5 data at we", last_wd, 5);
        chk(dq_oe == 1, "R5 keeps drive", dq_oe, 1);
        close_cycle();
        chk(last_kind == 3, "R5 kind", last_kind, 3);

        // R7 RAS-only refresh
        addr = 'h7E1; ras_n = 1'b0; tk(3);
        chk(dq_oe == 0, "R7 no drive", dq_oe, 0);
        chk(row_addr == 'h7E1, "R7 row", row_addr, 'h7E1);
        ras_n = 1'b1; tk(2);
        chk(last_kind == 4, "R7 kind", last_kind, 4);

        // R8 CAS-before-RAS refresh ignores addr
        cas_n = 1'b0; tk(1);
        addr = 'hFFF; ras_n = 1'b0; tk(2);
        chk(row_addr == exp_ref, "R8 counter row", row_addr, exp_ref);
        ras_n = 1'b1; tk(2);
        chk(last_kind == 5, "R8 kind", last_kind, 5);
        exp_ref++;

        // R9 successive refreshes with CAS held low
        for (int i = 0; i < 2; i++) begin
            r0 = nrep;
            ras_n = 1'b0; tk(2);
            chk(row_addr == exp_ref, "R9 next row", row_addr, exp_ref);
            ras_n = 1'b1; tk(2);
            chk(last_kind == 5 && nrep == r0 + 1, "R9 kind", last_kind, 5);
            exp_ref++;
        end
        cas_n = 1'b1; tk(2);

        // R10 hidden refresh keeps read data driven
        oe_n = 1'b0;
        open_read('h456, 'h089);
        tk(1);
        ras_n = 1'b1; tk(2);
        chk(last_kind == 1, "R10 read before hidden", last_kind, 1);
        chk(dq_oe == 1, "R10 drive between", dq_oe, 1);
        addr = 'h9AB; ras_n = 1'b0; tk(2);
        chk(row_addr == exp_ref, "R10 counter row", row_addr, exp_ref);
        chk(dq_oe == 1, "R10 drive during", dq_oe, 1);
        ras_n = 1'b1; tk(2);
        chk(last_kind == 6, "R10 kind", last_kind, 6);
        exp_ref++;
        cas_n = 1'b1; tk(2);
        chk(dq_oe == 0, "R10 release", dq_oe, 0);

        // R12 illegal column strobe with no row cycle
        r0 = nrep;
        cas_n = 1'b0; tk(2);
        cas_n = 1'b1; tk(2);
        chk(last_kind == 7 && nrep == r0 + 1, "R12 error kind", last_kind, 7);

        // R3 page mode: read then early write, last access reported
        addr = 'h321; ras_n = 1'b0; tk(1);
        addr = 'h011; tk(1);
        cas_n = 1'b0; tk(2);
        cas_n = 1'b1; addr = 'h022; we_n = 1'b0; tk(1);
        cas_n = 1'b0; tk(2);
        chk(col_addr == 'h022, "R2 page col", col_addr, 'h022);
        chk(dq_oe == 0, "R4 page write no drive", dq_oe, 0);
        close_cycle();
        chk(last_kind == 2, "R3 page kind", last_kind, 2);

        // R11 counter wrap through a long refresh train
        cas_n = 1'b0; tk(1);
        while (exp_ref != NROWS - 1) cbr_pulse();
        tk(1);
        ras_n = 1'b0; tk(2);
        chk(row_addr == NROWS - 1, "R11 top row", row_addr, NROWS - 1);
        ras_n = 1'b1; tk(2);
        exp_ref = 0;
        ras_n = 1'b0; tk(2);
        chk(row_addr == 0, "R11 wrap row", row_addr, 0);
        ras_n = 1'b1; tk(2);
        chk(last_kind == 5, "R11 kind", last_kind, 5);
        cas_n = 1'b1; tk(3);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(8 * 200000);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog expired t=%0t", $time);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule